// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Table Walker

This block translates 32-bit virtual byte addresses into 24-bit physical byte addresses with 1 KB pages. It keeps a four-entry, fully associative cache of recent translations. Each cache tag holds the current context number together with the 22-bit virtual page number. When a lookup hits, the physical address is formed combinationally in the same cycle, with the 10 offset bits carried through unchanged.

When a lookup misses, the request is held off with ready low. A hardware walker then reads one 16-bit page-table entry through a simple memory read port. The word address of that entry is the table base register plus the virtual page number. A resident entry is written into the cache, and the held request then completes as a hit. A non-resident entry completes the request with a fault flag for one cycle, and nothing is cached.

Two registers, the context number and the table base, are loaded together through a single write strobe. A context switch is just that register write. Entries of other contexts stay in the cache and simply stop matching, so switching back to an earlier context can hit at once without a flush.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every cache entry is invalid, the context register is 0 and the table base is 0. Outputs req_ready, tr_fault and mem_rd_valid are low, and the first request walks at word address 0 + VPN.
- R2: A request whose {context, VPN} matches a valid entry completes in the same cycle. In that cycle req_ready is high, tr_fault is low, tr_paddr = {cached PPN, vaddr[9:0]}, and no walk follows.
- R3: On a miss, mem_rd_valid rises in the next cycle with mem_rd_addr = (table base + VPN) mod 2^24. It stays high with a stable address until the cycle of mem_rd_ack, and req_ready stays low throughout.
- R4: A page-table entry has bit 15 = resident, bit 14 = dirty (ignored here) and bits 13:0 = PPN. A resident entry is cached at the ack, and the held request completes as a hit in the next cycle.
- R5: A non-resident entry makes req_ready and tr_fault high together for exactly the one cycle after the ack. Nothing is cached, so a retry walks again.
- R6: A hit needs a valid entry whose context and VPN both equal the current ones. The same VPN under another context misses and walks.
- R7: A cfg_we pulse loads the context and base registers, effective from the next cycle. Entries are not flushed: returning to an earlier context hits its entries without a walk.
- R8: A fill goes to the lowest-numbered invalid entry. When all four entries are valid, it goes to a round-robin pointer that starts at 0 after reset and advances by one, modulo 4, after each such replacement.
- R9: A lookup in the same cycle as a cfg_we pulse uses the context held before the write.
- R10: A walk uses the context, VPN and base captured when it starts. A register write during the walk does not change the entry address or the tag of the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load context and table base registers |
| cfg_ctx | input | 4 | New context number |
| cfg_ptbase | input | 24 | New page-table base (word address) |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual byte address |
| req_ready | output | 1 | Request completes this cycle |
| tr_paddr | output | 24 | Physical byte address (valid with ready and no fault) |
| tr_fault | output | 1 | Request completes with a page fault |
| mem_rd_valid | output | 1 | Walker read request |
| mem_rd_addr | output | 24 | Page-table entry word address |
| mem_rd_ack | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 16 | Page-table entry |

## Verification
Two events can land in the same cycle: a register write for a context switch, and a lookup or walk in flight. The bench pulses cfg_we in the first cycle of a request that hits under the old context, and expects a same-cycle hit with no walk; the next request under the new context must then walk. A second case pulses cfg_we one cycle into a slow walk. The fetched address must stay with the old base, the fill must carry the old context, and the held request must then walk again under the new context. A behavioural model compares every output on every cycle.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  parameter int VA_W    = 32;
  parameter int PA_W    = 24;
  parameter int OFF_W   = 10;
  parameter int CTX_W   = 4;
  parameter int MEM_AW  = 24;
  parameter int PTE_W   = 16;
  parameter int VPN_W   = VA_W - OFF_W;
  parameter int PPN_W   = PA_W - OFF_W;
  parameter int PTE_RES_BIT = PTE_W - 1;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic [VPN_W-1:0] vpn;
  } xl_tag_t;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_BUSY  = 2'd1,
    WK_FAULT = 2'd2
  } walk_st_e;
endpackage

// File: rtl/tlb_array.sv
module tlb_array
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  xl_tag_t            look_tag,
  output logic               hit,
  output logic [PPN_W-1:0]   hit_ppn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  xl_tag_t            fill_tag,
  input  logic [PPN_W-1:0]   fill_ppn,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  xl_tag_t            tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_en && (fill_idx == IDX_W'(e))) begin
        tag_q[e] <= fill_tag;
        ppn_q[e] <= fill_ppn;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == look_tag);
  end

  always_comb begin
    hit_ppn = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (match[e]) hit_ppn = hit_ppn | ppn_q[e];
  end

  assign hit       = |match;
  assign valid_vec = valid_q;

  // R6: tags are unique, so at most one entry may match
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic             all_valid;

  assign all_valid = &valid_vec;

  always_comb begin
    victim = rr_q;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!valid_vec[e]) victim = IDX_W'(e);
  end

  always_comb begin
    rr_d = rr_q;
    if (fill_en && all_valid)
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R8: with a free slot, the chosen slot must be free
  p_invalid_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !all_valid |-> !valid_vec[victim]);
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import ctx_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] start_addr,
  input  xl_tag_t           start_tag,
  output logic              idle,
  output logic              mem_rd_valid,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [PTE_W-1:0]  mem_rd_data,
  output logic              fill_en,
  output xl_tag_t           fill_tag,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic              fault
);
  walk_st_e          st_q, st_d;
  logic [MEM_AW-1:0] addr_q;
  xl_tag_t           tag_q;
  logic              cap_en;
  logic              resident;

  assign resident = mem_rd_data[PTE_RES_BIT];
  assign cap_en   = (st_q == WK_IDLE) && start;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WK_IDLE:  if (start) st_d = WK_BUSY;
      WK_BUSY:  if (mem_rd_ack) st_d = resident ? WK_IDLE : WK_FAULT;
      WK_FAULT: st_d = WK_IDLE;
      default:  st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= start_addr;
      tag_q  <= start_tag;
    end
  end

  assign idle         = (st_q == WK_IDLE);
  assign mem_rd_valid = (st_q == WK_BUSY);
  assign mem_rd_addr  = addr_q;
  assign fill_en      = (st_q == WK_BUSY) && mem_rd_ack && resident;
  assign fill_tag     = tag_q;
  assign fill_ppn     = mem_rd_data[PPN_W-1:0];
  assign fault        = (st_q == WK_FAULT);

  // R3: an unanswered read keeps its request and address
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ack |=> mem_rd_valid && $stable(mem_rd_addr));
  // R5: a fault only follows an ack of a non-resident entry
  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(mem_rd_valid && mem_rd_ack && !mem_rd_data[PTE_RES_BIT]));
  // R5: the fault lasts one cycle
  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  logic [MEM_AW-1:0] cfg_ptbase,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              req_ready,
  output logic [PA_W-1:0]   tr_paddr,
  output logic              tr_fault,
  output logic              mem_rd_valid,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [PTE_W-1:0]  mem_rd_data
);
  logic [CTX_W-1:0]   ctx_q, ctx_d;
  logic [MEM_AW-1:0]  ptb_q, ptb_d;
  xl_tag_t            look_tag;
  logic               hit;
  logic [PPN_W-1:0]   hit_ppn;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim;
  logic               walk_idle, walk_start, fill_en, fault;
  xl_tag_t            fill_tag;
  logic [PPN_W-1:0]   fill_ppn;
  logic [MEM_AW-1:0]  pte_addr;

  always_comb begin
    ctx_d = ctx_q;
    ptb_d = ptb_q;
    if (cfg_we) begin
      ctx_d = cfg_ctx;
      ptb_d = cfg_ptbase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
      ptb_q <= '0;
    end else begin
      ctx_q <= ctx_d;
      ptb_q <= ptb_d;
    end
  end

  assign look_tag   = '{ctx: ctx_q, vpn: req_vaddr[VA_W-1:OFF_W]};
  assign pte_addr   = ptb_q + MEM_AW'(req_vaddr[VA_W-1:OFF_W]);
  assign walk_start = walk_idle && req_valid && !hit;

  tlb_array #(.ENTRIES(ENTRIES)) u_array (
    .clk(clk), .rst_n(rst_n), .look_tag(look_tag), .hit(hit), .hit_ppn(hit_ppn),
    .fill_en(fill_en), .fill_idx(victim), .fill_tag(fill_tag), .fill_ppn(fill_ppn),
    .valid_vec(valid_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .fill_en(fill_en), .victim(victim)
  );

  tlb_walker u_walker (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .start_addr(pte_addr),
    .start_tag(look_tag), .idle(walk_idle), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_ppn(fill_ppn), .fault(fault)
  );

  assign req_ready = (walk_idle && req_valid && hit) || fault;
  assign tr_fault  = fault;
  assign tr_paddr  = {hit_ppn, req_vaddr[OFF_W-1:0]};

  // R3: the requester is stalled while the walker reads
  p_stall_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);
  // R2: a completed hit never starts a read in the following cycle
  p_hit_no_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !tr_fault |=> !mem_rd_valid);
endmodule

// File: tb/ctx_tlb_bench.sv
module ctx_tlb_bench;
  import ctx_tlb_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, cfg_we, req_valid, req_ready, tr_fault, mem_rd_valid, mem_rd_ack;
  logic [3:0]  cfg_ctx;
  logic [23:0] cfg_ptbase, tr_paddr, mem_rd_addr;
  logic [31:0] req_vaddr;
  logic [15:0] mem_rd_data;

  ctx_tlb u_ctx_tlb (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_ptbase(cfg_ptbase),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .tr_paddr(tr_paddr), .tr_fault(tr_fault), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, errors = 0;
  string cur_req = "R1";

  task automatic check_val(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // page table held by the bench and a latency-controlled responder
  logic [15:0] pt [int];
  int lat = 1;
  int wait_cnt = 0;
  always @(posedge clk) begin
    #1;
    mem_rd_ack  = 1'b0;
    mem_rd_data = 16'h0;
    if (rst_n && mem_rd_valid) begin
      if (wait_cnt >= lat) begin
        mem_rd_ack  = 1'b1;
        mem_rd_data = pt.exists(int'(mem_rd_addr)) ? pt[int'(mem_rd_addr)] : 16'h0;
        wait_cnt    = 0;
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  // behavioural reference model, compared on every cycle
  int m_st = 0, m_rr = 0, m_ctx = 0, m_ptb = 0, m_wctx = 0, m_wvpn = 0, m_waddr = 0;
  bit m_v [4];
  int m_tc [4], m_tv [4], m_pp [4];

  always @(negedge clk) begin
    if (rst_n) begin
      int vpn, off, hppn, vi;
      bit hit, exp_ready;
      vpn = int'(req_vaddr[31:10]);
      off = int'(req_vaddr[9:0]);
      hit = 0; hppn = 0;
      if (m_st == 0 && req_valid)
        for (int i = 0; i < 4; i++)
          if (m_v[i] && m_tc[i] == m_ctx && m_tv[i] == vpn) begin hit = 1; hppn = m_pp[i]; end
      exp_ready = hit || (m_st == 2);
      check_val(cur_req, "req_ready", 64'(req_ready), 64'(exp_ready));
      check_val(cur_req, "tr_fault", 64'(tr_fault), 64'(m_st == 2));
      check_val(cur_req, "mem_rd_valid", 64'(mem_rd_valid), 64'(m_st == 1));
      if (m_st == 1) check_val(cur_req, "mem_rd_addr", 64'(mem_rd_addr), 64'(m_waddr));
      if (hit) check_val(cur_req, "tr_paddr", 64'(tr_paddr), 64'(((hppn << 10) | off) & 24'hFFFFFF));
      case (m_st)
        0: if (req_valid && !hit) begin
             m_wctx = m_ctx; m_wvpn = vpn; m_waddr = (m_ptb + vpn) & 24'hFFFFFF; m_st = 1;
           end
        1: if (mem_rd_ack) begin
             if (mem_rd_data[15]) begin
               vi = -1;
               for (int i = 0; i < 4; i++) if (!m_v[i] && vi < 0) vi = i;
               if (vi < 0) begin vi = m_rr; m_rr = (m_rr + 1) % 4; end
               m_v[vi] = 1; m_tc[vi] = m_wctx; m_tv[vi] = m_wvpn; m_pp[vi] = int'(mem_rd_data[13:0]);
               m_st = 0;
             end else m_st = 2;
           end
        default: m_st = 0;
      endcase
      if (cfg_we) begin m_ctx = int'(cfg_ctx); m_ptb = int'(cfg_ptbase); end
    end
  end

  task automatic setcfg(input logic [3:0] c, input logic [23:0] b);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ctx = c; cfg_ptbase = b;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic translate(input logic [31:0] va, input int sw_at, input logic [3:0] sw_ctx,
                           input logic [23:0] sw_ptb, output logic [23:0] pa, output logic flt,
                           output bit walked, output logic [23:0] first_addr);
    int cyc = 0;
    walked = 0; first_addr = '0; pa = '0; flt = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = va;
    forever begin
      if (cyc == sw_at) begin cfg_we = 1'b1; cfg_ctx = sw_ctx; cfg_ptbase = sw_ptb; end
      else cfg_we = 1'b0;
      @(negedge clk);
      if (mem_rd_valid && !walked) begin walked = 1; first_addr = mem_rd_addr; end
      if (req_ready) begin pa = tr_paddr; flt = tr_fault; break; end
      @(posedge clk); #1;
      cyc++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic xl(input logic [31:0] va, output logic [23:0] pa, output logic flt,
                    output bit walked, output logic [23:0] fa);
    translate(va, -1, 4'h0, 24'h0, pa, flt, walked, fa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] pa, fa;
    logic flt;
    bit w;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ctx = '0; cfg_ptbase = '0;
    req_valid = 1'b0; req_vaddr = '0; mem_rd_ack = 1'b0; mem_rd_data = '0;
    pt[1] = 16'h8007; pt[32'h1006] = 16'h8002; pt[32'h1000] = 16'h0003;
    pt[32'h1001] = 16'hC009; pt[32'h2006] = 16'h8011; pt[32'h1002] = 16'h8020;
    pt[32'h1003] = 16'h8021; pt[32'h2002] = 16'h8050; pt[32'h1005] = 16'h8040;
    pt[32'h3005] = 16'h8041;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_val("R1", "req_ready in reset", 64'(req_ready), 64'd0);
    check_val("R1", "mem_rd_valid in reset", 64'(mem_rd_valid), 64'd0);
    check_val("R1", "tr_fault in reset", 64'(tr_fault), 64'd0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R1: context 0, base 0, empty cache
    cur_req = "R1";
    xl(32'h480, pa, flt, w, fa);
    check_val("R1", "walked", 64'(w), 64'd1);
    check_val("R1", "pte addr", 64'(fa), 64'h1);
    check_val("R1", "pa", 64'(pa), 64'h1C80);

    // R3/R4: miss then fill, R2: hit
    setcfg(4'd1, 24'h1000);
    cur_req = "R4";
    xl(32'h1804, pa, flt, w, fa);
    check_val("R3", "pte addr", 64'(fa), 64'h1006);
    check_val("R4", "pa after fill", 64'(pa), 64'h804);
    cur_req = "R2";
    xl(32'h1804, pa, flt, w, fa);
    check_val("R2", "hit walked", 64'(w), 64'd0);
    check_val("R2", "hit pa", 64'(pa), 64'h804);

    // R5: non-resident gives fault, no fill
    cur_req = "R5"; lat = 2;
    xl(32'h0FC, pa, flt, w, fa);
    check_val("R5", "fault", 64'(flt), 64'd1);
    xl(32'h0FC, pa, flt, w, fa);
    check_val("R5", "retry walks", 64'(w), 64'd1);
    check_val("R5", "retry fault", 64'(flt), 64'd1);

    // R4: dirty bit ignored
    cur_req = "R4"; lat = 0;
    xl(32'h480, pa, flt, w, fa);
    check_val("R4", "dirty entry pa", 64'(pa), 64'h2480);
    check_val("R4", "dirty entry fault", 64'(flt), 64'd0);

    // R6: other context misses; R7: back to old context hits
    setcfg(4'd2, 24'h2000);
    cur_req = "R6";
    xl(32'h1804, pa, flt, w, fa);
    check_val("R6", "other ctx walked", 64'(w), 64'd1);
    check_val("R6", "other ctx pa", 64'(pa), 64'h4404);
    setcfg(4'd1, 24'h1000);
    cur_req = "R7";
    xl(32'h1804, pa, flt, w, fa);
    check_val("R7", "no flush walked", 64'(w), 64'd0);
    check_val("R7", "no flush pa", 64'(pa), 64'h804);

    // R8: round-robin replacement once full
    cur_req = "R8"; lat = 1;
    xl(32'h800, pa, flt, w, fa);
    xl(32'hC00, pa, flt, w, fa);
    xl(32'h1804, pa, flt, w, fa);
    check_val("R8", "evicted entry walks", 64'(w), 64'd1);
    xl(32'h480, pa, flt, w, fa);
    check_val("R8", "second eviction walks", 64'(w), 64'd1);
    xl(32'h800, pa, flt, w, fa);
    check_val("R8", "kept entry walked", 64'(w), 64'd0);
    check_val("R8", "kept entry pa", 64'(pa), 64'h8000);

    // R9: lookup in the cycle of a context write uses the old context
    cur_req = "R9";
    translate(32'h800, 0, 4'd2, 24'h2000, pa, flt, w, fa);
    check_val("R9", "same-cycle walked", 64'(w), 64'd0);
    check_val("R9", "same-cycle pa", 64'(pa), 64'h8000);
    xl(32'h800, pa, flt, w, fa);
    check_val("R9", "new ctx walked", 64'(w), 64'd1);
    check_val("R9", "new ctx addr", 64'(fa), 64'h2002);
    check_val("R9", "new ctx pa", 64'(pa), 64'h14000);

    // R10: register write during a walk
    setcfg(4'd1, 24'h1000);
    cur_req = "R10"; lat = 3;
    translate(32'h1400, 1, 4'd3, 24'h3000, pa, flt, w, fa);
    check_val("R10", "captured addr", 64'(fa), 64'h1005);
    check_val("R10", "final pa new ctx", 64'(pa), 64'h10400);
    setcfg(4'd1, 24'h1000);
    xl(32'h1400, pa, flt, w, fa);
    check_val("R10", "old ctx fill walked", 64'(w), 64'd0);
    check_val("R10", "old ctx fill pa", 64'(pa), 64'h10000);

    // R3: address wraps modulo 2^24
    setcfg(4'd4, 24'hFFFFFF);
    cur_req = "R3"; lat = 0;
    xl(32'h800, pa, flt, w, fa);
    check_val("R3", "wrapped addr", 64'(fa), 64'h1);
    check_val("R3", "wrapped pa", 64'(pa), 64'h1C00);

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule